// File: doc/BRIEF.md
# ATA Task-File Command Controller

This block is the device side of a parallel ATA style disk port. A host performs byte-wide register reads and writes at eight task-file offsets. The block stores the sector count, the three address bytes and the device/head byte, and presents a status byte. A write to the command offset starts a command sequence.

Four commands are decoded. IDENTIFY runs as a PIO data-in transfer of 256 16-bit words from an identify image generated inside the block. FLUSH CACHE keeps the device busy until an external completion strobe arrives. READ DMA and WRITE DMA are forwarded to a transfer port as a request carrying a 24-bit LBA, a sector count and a direction, and they finish when the transfer engine strobes done. The block raises an interrupt line when a command needs the host's attention, and any status read drops that line. Any other opcode is rejected with an error.

The reset input is asserted asynchronously and released through a two-flop synchronizer, so the block responds two clock cycles after the external release.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset the status byte reads 0x40 (only the ready bit, bit 6, is set), the interrupt is low and no transfer request is raised.
- R2: Bytes written at offsets 2 (count), 3 (LBA bits 7:0), 4 (LBA bits 15:8), 5 (LBA bits 23:16) and 6 (device) read back unchanged at the same offsets. Bit 4 of the device byte selects device 1 and reads 0 when device 0 is written. Writes to these offsets are ignored while busy (status bit 7) is set.
- R3: After opcode 0xEC the status reads 0x48 (ready plus data-request, bit 3) before each of 256 reads of offset 0. After the 256th read the status reads 0x40.
- R4: Identify word 85 has bit 5 set. Words 10 to 19 hold the 20-character serial string and words 23 to 26 hold the 8-character revision string, with the earlier character of each pair in bits 15:8. All other words read 0.
- R5: After opcode 0xE7 the status reads 0xC0 (busy and ready) until the flush-done strobe. After the strobe it reads 0x40 and the interrupt rises.
- R6: Opcode 0xC8 (to host) or 0xCA (from host) raises the transfer request with LBA {offset 5, offset 4, offset 3}, count from offset 2, and a direction flag that is 1 for 0xC8. The status reads 0xC0 while the request is up. After the transfer-done strobe the request drops, the status reads 0x40 and the interrupt rises.
- R7: The interrupt stays high after a completion or after IDENTIFY data is ready, until a status read. The interrupt is low after that read.
- R8: An opcode other than 0xEC, 0xE7, 0xC8 and 0xCA makes the status read 0x41 (ready plus error, bit 0) and raises the interrupt.
- R9: A command written while busy is set is ignored. The running command and its status are unchanged.
- R10: An accepted command clears a pending error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tf_addr | input | 3 | Task-file offset |
| tf_wr | input | 1 | Host write strobe, one cycle per access |
| tf_rd | input | 1 | Host read strobe, one cycle per access |
| tf_wdata | input | 8 | Host write byte |
| tf_rdata | output | 16 | Read data: word at offset 0, byte in bits 7:0 elsewhere |
| flush_done | input | 1 | Cache flush completion strobe |
| xfer_req | output | 1 | DMA transfer request, level |
| xfer_to_host | output | 1 | 1 for a device-to-host transfer |
| xfer_lba | output | 24 | Starting LBA of the transfer |
| xfer_count | output | 8 | Sector count of the transfer |
| xfer_done | input | 1 | DMA transfer completion strobe |
| intrq | output | 1 | Interrupt to the host |

## Verification
The sequencer is driven with each of its four accepted opcodes, with an unknown opcode, and with a command written during a busy phase. This separates the PIO path, the externally timed busy phase, the request hand-off and the error path from one another. Two DMA requests use different LBA bytes and opposite directions, which exposes swapped address bytes or a wrong direction flag. The IDENTIFY run samples the status before every word and compares every word against its expected content, so an off-by-one in the word count or a wrong byte order in the strings shows up. Status reads are placed before and after each completion to show when the interrupt is set and when it is released.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam logic [7:0] OP_IDENTIFY = 8'hEC;
  localparam logic [7:0] OP_FLUSH    = 8'hE7;
  localparam logic [7:0] OP_RD_DMA   = 8'hC8;
  localparam logic [7:0] OP_WR_DMA   = 8'hCA;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_COUNT = 3'd2;
  localparam logic [2:0] OFS_LBA0  = 3'd3;
  localparam logic [2:0] OFS_LBA1  = 3'd4;
  localparam logic [2:0] OFS_LBA2  = 3'd5;
  localparam logic [2:0] OFS_DEV   = 3'd6;
  localparam logic [2:0] OFS_CMD   = 3'd7;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PIO   = 2'd1,
    SQ_FLUSH = 2'd2,
    SQ_XFER  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       busy,
  output logic [7:0] count,
  output logic [7:0] lba0,
  output logic [7:0] lba1,
  output logic [7:0] lba2,
  output logic [7:0] dev
);
  import ata_tf_pkg::*;

  logic [7:0] count_n, lba0_n, lba1_n, lba2_n, dev_n;
  logic       wr_ok;

  assign wr_ok = wr && !busy;

  always_comb begin
    count_n = count;
    lba0_n  = lba0;
    lba1_n  = lba1;
    lba2_n  = lba2;
    dev_n   = dev;
    if (wr_ok) begin
      case (addr)
        OFS_COUNT: count_n = wdata;
        OFS_LBA0:  lba0_n  = wdata;
        OFS_LBA1:  lba1_n  = wdata;
        OFS_LBA2:  lba2_n  = wdata;
        OFS_DEV:   dev_n   = wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      lba0  <= '0;
      lba1  <= '0;
      lba2  <= '0;
      dev   <= '0;
    end else begin
      count <= count_n;
      lba0  <= lba0_n;
      lba1  <= lba1_n;
      lba2  <= lba2_n;
      dev   <= dev_n;
    end
  end

  // R2
  regs_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr) |=> ($stable(lba0) && $stable(lba1) && $stable(lba2) && $stable(count)));
endmodule

// File: rtl/ata_tf_idrom.sv
module ata_tf_idrom #(
  parameter int          WORDS  = 256,
  parameter logic [159:0] SERIAL = "TF0000000000SN000042",
  parameter logic [63:0]  REV    = "REV-0001",
  localparam int         IW     = $clog2(WORDS)
) (
  input  logic [IW-1:0] idx,
  output logic [15:0]   word
);
  localparam int SER_LO = 10;
  localparam int SER_HI = SER_LO + 9;
  localparam int REV_LO = 23;
  localparam int REV_HI = REV_LO + 3;
  localparam int CACHE_WORD = 85;

  int unsigned i;

  always_comb begin
    i    = 32'(idx);
    word = 16'h0000;
    if (i >= SER_LO && i <= SER_HI)
      word = SERIAL[159 - 16*(i - SER_LO) -: 16];
    else if (i >= REV_LO && i <= REV_HI)
      word = REV[63 - 16*(i - REV_LO) -: 16];
    else if (i == CACHE_WORD)
      word = 16'h0020;
  end
endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq #(
  parameter int  WORDS = 256,
  localparam int IW    = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_wr,
  input  logic [7:0]              cmd,
  input  logic                    stat_rd,
  input  logic                    data_rd,
  input  logic                    flush_done,
  input  logic                    xfer_done,
  output ata_tf_pkg::seq_state_t  state,
  output logic [IW-1:0]           idx,
  output logic                    err,
  output logic                    irq,
  output logic                    to_host
);
  import ata_tf_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  seq_state_t    state_n;
  logic [IW-1:0] idx_n;
  logic          err_n, irq_set, to_host_n, busy;

  assign busy = (state == SQ_FLUSH) || (state == SQ_XFER);

  always_comb begin
    state_n   = state;
    idx_n     = idx;
    err_n     = err;
    to_host_n = to_host;
    irq_set   = 1'b0;
    case (state)
      SQ_FLUSH: if (flush_done) begin
        state_n = SQ_IDLE;
        irq_set = 1'b1;
      end
      SQ_XFER: if (xfer_done) begin
        state_n = SQ_IDLE;
        irq_set = 1'b1;
      end
      default: begin
        if (cmd_wr) begin
          err_n = 1'b0;
          case (cmd)
            OP_IDENTIFY: begin
              state_n = SQ_PIO;
              idx_n   = '0;
              irq_set = 1'b1;
            end
            OP_FLUSH: state_n = SQ_FLUSH;
            OP_RD_DMA, OP_WR_DMA: begin
              state_n   = SQ_XFER;
              to_host_n = (cmd == OP_RD_DMA);
            end
            default: begin
              state_n = SQ_IDLE;
              err_n   = 1'b1;
              irq_set = 1'b1;
            end
          endcase
        end else if (state == SQ_PIO && data_rd) begin
          if (idx == LAST) state_n = SQ_IDLE;
          else             idx_n   = idx + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      idx     <= '0;
      err     <= 1'b0;
      irq     <= 1'b0;
      to_host <= 1'b0;
    end else begin
      state   <= state_n;
      idx     <= idx_n;
      err     <= err_n;
      to_host <= to_host_n;
      if (irq_set)      irq <= 1'b1;
      else if (stat_rd) irq <= 1'b0;
    end
  end

  // R9
  cmd_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr && !flush_done && !xfer_done) |=> $stable(state));
  // R7
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cmd_wr && !flush_done && !xfer_done) |=> !irq);
  // R5
  flush_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_FLUSH && !flush_done) |=> (state == SQ_FLUSH));
  // R3
  pio_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_PIO && data_rd && !cmd_wr && idx == LAST) |=> (state == SQ_IDLE));
endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl #(
  parameter int           ID_WORDS  = 256,
  parameter logic [159:0] ID_SERIAL = "TF0000000000SN000042",
  parameter logic [63:0]  ID_REV    = "REV-0001"
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  tf_addr,
  input  logic        tf_wr,
  input  logic        tf_rd,
  input  logic [7:0]  tf_wdata,
  output logic [15:0] tf_rdata,
  input  logic        flush_done,
  output logic        xfer_req,
  output logic        xfer_to_host,
  output logic [23:0] xfer_lba,
  output logic [7:0]  xfer_count,
  input  logic        xfer_done,
  output logic        intrq
);
  import ata_tf_pkg::*;

  localparam int IW = $clog2(ID_WORDS);

  logic [1:0]    rst_sync;
  logic          rst_in_n;
  seq_state_t    state;
  logic [IW-1:0] idx;
  logic          err, busy, drq;
  logic [7:0]    count, lba0, lba1, lba2, dev, status;
  logic [15:0]   id_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_in_n = rst_sync[1];

  assign busy   = (state == SQ_FLUSH) || (state == SQ_XFER);
  assign drq    = (state == SQ_PIO);
  assign status = {busy, 1'b1, 1'b0, 1'b0, drq, 2'b00, err};

  ata_tf_regs u_regs (
    .clk(clk), .rst_n(rst_in_n), .wr(tf_wr), .addr(tf_addr),
    .wdata(tf_wdata), .busy(busy), .count(count),
    .lba0(lba0), .lba1(lba1), .lba2(lba2), .dev(dev)
  );

  ata_tf_idrom #(.WORDS(ID_WORDS), .SERIAL(ID_SERIAL), .REV(ID_REV)) u_idrom (
    .idx(idx), .word(id_word)
  );

  ata_tf_seq #(.WORDS(ID_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_in_n),
    .cmd_wr(tf_wr && tf_addr == OFS_CMD), .cmd(tf_wdata),
    .stat_rd(tf_rd && tf_addr == OFS_CMD),
    .data_rd(tf_rd && tf_addr == OFS_DATA),
    .flush_done(flush_done), .xfer_done(xfer_done),
    .state(state), .idx(idx), .err(err), .irq(intrq), .to_host(xfer_to_host)
  );

  always_comb begin
    case (tf_addr)
      OFS_DATA:  tf_rdata = drq ? id_word : 16'h0000;
      OFS_COUNT: tf_rdata = {8'h00, count};
      OFS_LBA0:  tf_rdata = {8'h00, lba0};
      OFS_LBA1:  tf_rdata = {8'h00, lba1};
      OFS_LBA2:  tf_rdata = {8'h00, lba2};
      OFS_DEV:   tf_rdata = {8'h00, dev};
      OFS_CMD:   tf_rdata = {8'h00, status};
      default:   tf_rdata = 16'h0000;
    endcase
  end

  assign xfer_req   = (state == SQ_XFER);
  assign xfer_lba   = {lba2, lba1, lba0};
  assign xfer_count = count;

  // R6
  xfer_args_stable_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    (xfer_req && $past(xfer_req)) |-> ($stable(xfer_lba) && $stable(xfer_count)));
  // R6
  xfer_busy_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    xfer_req |-> status[7]);
endmodule

// File: tb/ata_taskfile_ctrl_bench.sv
module ata_taskfile_ctrl_bench;
  localparam logic [159:0] SER = "TF0000000000SN000042";
  localparam logic [63:0]  REV = "REV-0001";

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tf_addr = '0;
  logic        tf_wr = 1'b0, tf_rd = 1'b0;
  logic [7:0]  tf_wdata = '0;
  logic [15:0] tf_rdata;
  logic        flush_done = 1'b0, xfer_done = 1'b0;
  logic        xfer_req, xfer_to_host, intrq;
  logic [23:0] xfer_lba;
  logic [7:0]  xfer_count;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  ata_taskfile_ctrl u_ata_taskfile_ctrl (
    .clk(clk), .rst_n(rst_n), .tf_addr(tf_addr), .tf_wr(tf_wr), .tf_rd(tf_rd),
    .tf_wdata(tf_wdata), .tf_rdata(tf_rdata), .flush_done(flush_done),
    .xfer_req(xfer_req), .xfer_to_host(xfer_to_host), .xfer_lba(xfer_lba),
    .xfer_count(xfer_count), .xfer_done(xfer_done), .intrq(intrq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); tf_addr = a; tf_wdata = d; tf_wr = 1'b1;
    @(negedge clk); tf_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); tf_addr = a; tf_rd = 1'b1; #2 d = tf_rdata;
    @(negedge clk); tf_rd = 1'b0;
  endtask

  task automatic strobe_flush();
    @(negedge clk); flush_done = 1'b1; @(negedge clk); flush_done = 1'b0;
  endtask

  task automatic strobe_xfer();
    @(negedge clk); xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    #1 chk("R1 intrq", int'(intrq), 0);
    chk("R1 xfer_req", int'(xfer_req), 0);
    rd(3'd7, d); chk("R1 status", int'(d[7:0]), 8'h40);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(3'd2, 8'h5A); wr(3'd3, 8'h11); wr(3'd4, 8'h22); wr(3'd5, 8'h33);
    wr(3'd6, 8'h40);
    rd(3'd2, d); chk("R2 count", int'(d[7:0]), 8'h5A);
    rd(3'd3, d); chk("R2 lba0", int'(d[7:0]), 8'h11);
    rd(3'd4, d); chk("R2 lba1", int'(d[7:0]), 8'h22);
    rd(3'd5, d); chk("R2 lba2", int'(d[7:0]), 8'h33);
    rd(3'd6, d); chk("R2 dev bit", int'(d[4]), 0);
    chk("R2 dev lba", int'(d[7:0]), 8'h40);
  endtask

  function automatic logic [15:0] exp_word(input int w);
    if (w >= 10 && w <= 19) return SER[159 - 16*(w-10) -: 16];
    if (w >= 23 && w <= 26) return REV[63 - 16*(w-23) -: 16];
    if (w == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  task automatic t_identify();
    logic [15:0] d, s;
    int bad_st = 0, bad_wd = 0;
    wr(3'd6, 8'h00);
    wr(3'd7, 8'hEC);
    #1 chk("R7 irq after identify", int'(intrq), 1);
    for (int w = 0; w < 256; w++) begin
      rd(3'd7, s);
      if (s[7:0] !== 8'h48) bad_st++;
      rd(3'd0, d);
      if (d !== exp_word(w)) begin
        bad_wd++;
        if (bad_wd == 1) $display("FAIL R4 word %0d: actual 0x%0h expected 0x%0h", w, d, exp_word(w));
      end
      if (w == 85) chk("R4 write-cache bit", int'(d[5]), 1);
    end
    chk("R7 irq cleared by status read", int'(intrq), 0);
    chk("R3 status before words (bad count)", bad_st, 0);
    chk("R4 identify words (bad count)", bad_wd, 0);
    rd(3'd7, s); chk("R3 status after last word", int'(s[7:0]), 8'h40);
  endtask

  task automatic t_flush_and_ignore();
    logic [15:0] s;
    wr(3'd7, 8'hE7);
    rd(3'd7, s); chk("R5 flush in flight", int'(s[7:0]), 8'hC0);
    wr(3'd7, 8'hEC);
    rd(3'd7, s); chk("R9 command ignored while busy", int'(s[7:0]), 8'hC0);
    wr(3'd3, 8'h99);
    rd(3'd3, s); chk("R2 write ignored while busy", int'(s[7:0]), 8'h11);
    repeat (5) @(negedge clk);
    rd(3'd7, s); chk("R5 still busy", int'(s[7:0]), 8'hC0);
    chk("R9 no request", int'(xfer_req), 0);
    strobe_flush();
    #1 chk("R5 irq on flush done", int'(intrq), 1);
    rd(3'd7, s); chk("R5 flush complete", int'(s[7:0]), 8'h40);
    chk("R7 irq released", int'(intrq), 0);
  endtask

  task automatic t_dma(input logic [7:0] op, input logic [23:0] lba, input logic [7:0] cnt);
    logic [15:0] s;
    wr(3'd2, cnt); wr(3'd3, lba[7:0]); wr(3'd4, lba[15:8]); wr(3'd5, lba[23:16]);
    wr(3'd7, op);
    #1 chk("R6 request", int'(xfer_req), 1);
    chk("R6 lba", int'(xfer_lba), int'(lba));
    chk("R6 count", int'(xfer_count), int'(cnt));
    chk("R6 direction", int'(xfer_to_host), (op == 8'hC8) ? 1 : 0);
    chk("R7 no irq while busy", int'(intrq), 0);
    rd(3'd7, s); chk("R6 busy status", int'(s[7:0]), 8'hC0);
    strobe_xfer();
    #1 chk("R6 request dropped", int'(xfer_req), 0);
    chk("R7 irq on transfer done", int'(intrq), 1);
    rd(3'd7, s); chk("R6 done status", int'(s[7:0]), 8'h40);
    chk("R7 irq released", int'(intrq), 0);
  endtask

  task automatic t_unknown();
    logic [15:0] s;
    wr(3'd7, 8'h20);
    #1 chk("R8 irq on unknown", int'(intrq), 1);
    rd(3'd7, s); chk("R8 error status", int'(s[7:0]), 8'h41);
    wr(3'd7, 8'hE7);
    rd(3'd7, s); chk("R10 error cleared by new command", int'(s[7:0]), 8'hC0);
    strobe_flush();
    rd(3'd7, s); chk("R10 clean completion", int'(s[7:0]), 8'h40);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_identify();
    t_flush_and_ignore();
    t_dma(8'hC8, 24'hABCDEF, 8'h08);
    t_dma(8'hCA, 24'h010203, 8'h01);
    t_unknown();
    finish_run();
  end
endmodule